// File: doc/BRIEF.md
# Threshold Alert Comparator

This block watches a stream of signed conversion results and turns them into a single alert line with a separate output enable. Each time a result-valid strobe arrives, the result is compared against a programmable low threshold and a programmable high threshold. The comparator can run in two modes. In window mode it flags results outside the band. In traditional mode it flags results above the high threshold, and it applies hysteresis down to the low threshold.

A 2-bit queue field does two jobs. It sets how many consecutive out-of-threshold results must arrive before the alert fires (one, two or four), and its fourth code turns the comparator off and releases the line to high impedance. A latch option holds a fired alert until the host reads the data or sends an alert-response clear. A polarity option selects the active level. When the high threshold has its sign bit set and the low threshold has its sign bit clear, the line stops reporting threshold events and becomes a ready indicator instead.

The block is placed between the converter's result path and the register bank, which supply its data and configuration inputs.

Top module: `thresh_alert`

## Requirements
- R1: Thresholds and results are compared as signed two's-complement values of DW bits (default 16), so 16'h8000 is the most negative value and 16'h7FFF the most positive.
- R2: The queue field selects the number of consecutive out-of-threshold results needed to set the alert: 2'b00 one, 2'b01 two, 2'b10 four. Any result that is not out of threshold resets the consecutive count to zero.
- R3: Queue field 2'b11 disables the comparator: alert_oe is 0, alert_o sits at the inactive level, and the count and alert state are held cleared.
- R4: Window mode (cfg_window=1) treats a result as out of threshold when it is greater than thr_hi or less than thr_lo. When not latching, the next in-band result clears the alert.
- R5: Traditional mode (cfg_window=0) treats only results greater than thr_hi as out of threshold. When not latching, the alert clears only on a result less than thr_lo; a result inside the band holds the current state.
- R6: alert_o equals the active indication when cfg_pol=1 and its inverse when cfg_pol=0. This applies in every mode, including ready mode.
- R7: With cfg_latch=1, a set alert stays set until rd_clr or ack_clr is sampled high. A clear is applied before a result arriving in the same cycle, and that result may set the alert again.
- R8: When thr_hi[DW-1]=1 and thr_lo[DW-1]=0 (ready mode, queue not 2'b11), the threshold comparator state is held cleared. With cfg_single=1 the active indication follows status_idle. With cfg_single=0 the indication is active for exactly the one cycle after each result-valid strobe.
- R9: After reset the alert and count are clear, so alert_o shows the inactive level. Outside ready mode, an alert change caused by a strobe becomes visible on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | New conversion result strobe |
| res_data | input | DW | Signed conversion result |
| cfg_window | input | 1 | 1 selects window mode, 0 traditional |
| cfg_pol | input | 1 | 1 active high, 0 active low |
| cfg_latch | input | 1 | 1 latches a set alert |
| cfg_queue | input | 2 | Consecutive-count select; 2'b11 disables |
| cfg_single | input | 1 | 1 single-shot, 0 continuous (ready mode) |
| status_idle | input | 1 | Converter idle status (1 = not converting) |
| thr_lo | input | DW | Signed low threshold |
| thr_hi | input | DW | Signed high threshold |
| rd_clr | input | 1 | Conversion data read, clears a latched alert |
| ack_clr | input | 1 | Alert-response clear for a latched alert |
| alert_o | output | 1 | Alert/ready line value |
| alert_oe | output | 1 | Line output enable (0 = high impedance) |

## Verification
The hardest state to reach is a four-deep queue that is interrupted by a single in-band result just before it would fire, while latching is active. Only an uninterrupted run of four results should set the alert, and the set state should then survive further in-band results. Directed sequences build such runs and break them, and randomly drawn thresholds are kept narrow around a narrow data range, so random runs of out-of-threshold results of every length occur often. Occasional full-range draws reach the sign-bit extremes and the ready-mode threshold pattern.

// File: rtl/thresh_alert.sv
module thresh_alert #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          cfg_window,
  input  logic          cfg_pol,
  input  logic          cfg_latch,
  input  logic [1:0]    cfg_queue,
  input  logic          cfg_single,
  input  logic          status_idle,
  input  logic [DW-1:0] thr_lo,
  input  logic [DW-1:0] thr_hi,
  input  logic          rd_clr,
  input  logic          ack_clr,
  output logic          alert_o,
  output logic          alert_oe
);

  localparam int CW = 3;

  logic          alert_q, alert_n, pulse_q;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc, need;
  logic          above, below, oot, disabled, rdy_mode, active;

  assign above    = $signed(res_data) > $signed(thr_hi);
  assign below    = $signed(res_data) < $signed(thr_lo);
  assign oot      = above | (cfg_window & below);
  assign disabled = (cfg_queue == 2'b11);
  assign rdy_mode = thr_hi[DW-1] & ~thr_lo[DW-1];
  assign cnt_inc  = (cnt_q == CW'(4)) ? CW'(4) : cnt_q + CW'(1);

  always_comb begin
    case (cfg_queue)
      2'b00:   need = CW'(1);
      2'b01:   need = CW'(2);
      default: need = CW'(4);
    endcase
  end

  always_comb begin
    cnt_n   = cnt_q;
    alert_n = alert_q;
    if (disabled || rdy_mode) begin
      cnt_n   = '0;
      alert_n = 1'b0;
    end else begin
      if (cfg_latch && (rd_clr || ack_clr)) alert_n = 1'b0;
      if (res_valid) begin
        cnt_n = oot ? cnt_inc : '0;
        if (oot && (cnt_inc >= need)) alert_n = 1'b1;
        else if (!cfg_latch && (cfg_window ? !oot : below)) alert_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      alert_q <= alert_n;
      cnt_q   <= cnt_n;
      pulse_q <= res_valid;
    end
  end

  assign active   = rdy_mode ? (cfg_single ? status_idle : pulse_q) : alert_q;
  assign alert_oe = ~disabled;
  assign alert_o  = (active & ~disabled) ^ ~cfg_pol;

  // R3
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> (!alert_q && cnt_q == '0));

  // R9
  rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_q) |-> $past(res_valid));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch && alert_q && !rd_clr && !ack_clr && !disabled && !rdy_mode) |=> alert_q);

  // R4
  window_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_window && !cfg_latch && !disabled && !rdy_mode && !above && !below)
    |=> !alert_q);

endmodule

// File: tb/test_thresh_alert.sv
module test_thresh_alert;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic res_valid = 0, cfg_window = 0, cfg_pol = 0, cfg_latch = 0;
  logic cfg_single = 0, status_idle = 1, rd_clr = 0, ack_clr = 0;
  logic [1:0] cfg_queue = 2'b00;
  logic [15:0] res_data = 0, thr_lo = 16'hFFF6, thr_hi = 16'd10;
  logic alert_o, alert_oe;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit m_alert = 0, m_pulse = 0;
  int m_cnt = 0;

  thresh_alert #(.DW(16)) i_thresh_alert (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .cfg_window(cfg_window), .cfg_pol(cfg_pol), .cfg_latch(cfg_latch),
    .cfg_queue(cfg_queue), .cfg_single(cfg_single), .status_idle(status_idle),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .rd_clr(rd_clr), .ack_clr(ack_clr),
    .alert_o(alert_o), .alert_oe(alert_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_rdy();
    return thr_hi[15] && !thr_lo[15];
  endfunction

  function automatic int need_of(logic [1:0] q);
    return (q == 2'b00) ? 1 : (q == 2'b01) ? 2 : 4;
  endfunction

  task automatic model(bit v, logic [15:0] d, bit rc, bit ac);
    shortint sd, slo, shi;
    bit up, dn, out;
    sd = shortint'(d); slo = shortint'(thr_lo); shi = shortint'(thr_hi);
    if (cfg_queue == 2'b11 || is_rdy()) begin
      m_cnt = 0; m_alert = 0;
    end else begin
      if (cfg_latch && (rc || ac)) m_alert = 0;
      if (v) begin
        up = sd > shi; dn = sd < slo;
        out = cfg_window ? (up | dn) : up;
        m_cnt = out ? ((m_cnt < 4) ? m_cnt + 1 : 4) : 0;
        if (out && m_cnt >= need_of(cfg_queue)) m_alert = 1;
        else if (!cfg_latch && (cfg_window ? !out : dn)) m_alert = 0;
      end
    end
    m_pulse = v;
  endtask

  task automatic check(string tag);
    bit act, eo, eoe;
    eoe = (cfg_queue != 2'b11);
    act = is_rdy() ? (cfg_single ? status_idle : m_pulse) : m_alert;
    eo  = !eoe ? !cfg_pol : (cfg_pol ? act : !act);
    n_tests++;
    if (alert_o !== eo || alert_oe !== eoe) begin
      n_fail++;
      $display("FAIL %s: alert_o=%b oe=%b expected alert_o=%b oe=%b", tag, alert_o, alert_oe, eo, eoe);
    end
  endtask

  task automatic step(bit v, logic [15:0] d, bit rc, bit ac, string tag);
    @(negedge clk);
    res_valid = v; res_data = d; rd_clr = rc; ack_clr = ac;
    model(v, d, rc, ac);
    @(negedge clk);
    res_valid = 0; rd_clr = 0; ack_clr = 0;
    check(tag);
  endtask

  task automatic set_cfg(bit w, bit p, bit l, logic [1:0] q, logic [15:0] lo, logic [15:0] hi);
    @(negedge clk);
    cfg_window = w; cfg_pol = p; cfg_latch = l; cfg_queue = q; thr_lo = lo; thr_hi = hi;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset");

    // R2 queue of two, broken run then full run
    set_cfg(1, 0, 0, 2'b01, 16'hFFF6, 16'd10);
    step(1, 16'd20, 0, 0, "R2 q2 first");
    step(1, 16'd0,  0, 0, "R2 q2 reset by in-band");
    step(1, 16'd20, 0, 0, "R2 q2 first again");
    step(1, 16'd20, 0, 0, "R2 q2 second sets");
    step(1, 16'd0,  0, 0, "R4 window in-band clears");

    // R2 queue of four, with latch
    set_cfg(1, 1, 1, 2'b10, 16'hFFF6, 16'd10);
    for (int i = 0; i < 3; i++) step(1, 16'hFF00, 0, 0, "R2 q4 partial");
    step(1, 16'd0, 0, 0, "R2 q4 interrupted");
    for (int i = 0; i < 4; i++) step(1, 16'hFF00, 0, 0, "R2 q4 run");
    step(1, 16'd0, 0, 0, "R7 latched holds");
    step(0, 16'd0, 1, 0, "R7 read clears");
    step(1, 16'd50, 0, 0, "R2 q4 restart");
    // R1 extremes
    set_cfg(1, 1, 1, 2'b00, 16'hFFF6, 16'd10);
    step(1, 16'h8000, 0, 0, "R1 most negative below");
    step(1, 16'd0, 1, 0, "R7 clear then in-band");
    step(1, 16'h7FFF, 0, 1, "R7 ack clear with new set");
    step(0, 16'd0, 0, 1, "R7 ack clears");

    // R5 traditional hysteresis
    set_cfg(0, 0, 0, 2'b00, 16'hFFF6, 16'd10);
    step(1, 16'hFF00, 0, 0, "R5 below does not set");
    step(1, 16'd11, 0, 0, "R5 above sets");
    step(1, 16'd0,  0, 0, "R5 in band holds");
    step(1, 16'hFFF5, 0, 0, "R5 below clears");
    set_cfg(0, 1, 0, 2'b00, 16'hFFF6, 16'd10);
    step(1, 16'd10, 0, 0, "R6 equal not above");
    step(1, 16'd12, 0, 0, "R6 active high");

    // R3 disable
    set_cfg(0, 1, 0, 2'b11, 16'hFFF6, 16'd10);
    step(1, 16'd100, 0, 0, "R3 disabled");
    set_cfg(0, 0, 0, 2'b11, 16'hFFF6, 16'd10);
    step(1, 16'd100, 0, 0, "R3 disabled low pol");
    set_cfg(0, 1, 0, 2'b00, 16'hFFF6, 16'd10);
    step(0, 16'd0, 0, 0, "R3 state cleared after disable");

    // R8 ready mode
    set_cfg(0, 1, 0, 2'b00, 16'h0000, 16'h8000);
    cfg_single = 0;
    step(1, 16'd5, 0, 0, "R8 continuous pulse");
    step(0, 16'd5, 0, 0, "R8 pulse one cycle");
    cfg_pol = 0;
    step(1, 16'd5, 0, 0, "R8 pulse active low");
    cfg_single = 1; status_idle = 0;
    step(0, 16'd0, 0, 0, "R8 single busy");
    status_idle = 1;
    step(0, 16'd0, 0, 0, "R8 single idle");
    cfg_single = 0;

    // random mix
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 19) == 0) begin
        cfg_window = 1'($urandom); cfg_pol = 1'($urandom); cfg_latch = 1'($urandom);
        cfg_queue = 2'($urandom); cfg_single = 1'($urandom); status_idle = 1'($urandom);
        if ($urandom_range(0, 7) == 0) begin
          thr_lo = 16'($urandom); thr_hi = 16'($urandom);
        end else begin
          thr_lo = 16'(-int'($urandom_range(1, 8)));
          thr_hi = 16'($urandom_range(0, 8));
        end
      end
      step(1'($urandom_range(0, 3) != 0),
           ($urandom_range(0, 15) == 0) ? 16'($urandom) : 16'(int'($urandom_range(0, 30)) - 15),
           $urandom_range(0, 9) == 0, $urandom_range(0, 14) == 0, "R2 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule